// File: doc/BRIEF.md
# Masked Address Trap Decoder

This block observes a simple host bus and reports accesses that land in any of three programmable device windows. Each window has a one-byte control register and a two-byte base address. The top bit of the control byte picks the address space. In I/O space the control byte holds separate enables for read and write trapping and a mask over the five lowest address bits. In memory space the control byte masks address bits 15 down to 9, and bits 8 down to 0 never take part in the compare. That gives windows from 512 bytes up to 64 KB.

A matching access produces a trap request one clock later and sets the window's bit in a status byte. Software clears that byte by writing ones to it. A further write-only register raises a trap request on every write, whatever data is written. All registers sit behind a small synchronous index/data port.

Top module: `addr_trap_decoder`

## Requirements
- R1: Control registers sit at indices 0, 1 and 2 (windows 0..2). Base registers sit at indices 8/9, 10/11 and 12/13 (low byte, then high byte). After reset every control byte reads 00h and every base reads 0000h. A written value reads back unchanged.
- R2: With control bit 7 = 0 (I/O), all 16 address bits are compared with the base, except the bits among A[4:0] whose control mask bit (bits 4:0) is 1. A mask bit of 0 requires equality.
- R3: In I/O mode, control bit 6 = 1 enables trapping of write cycles and bit 5 = 1 enables trapping of read cycles. When an enable is 0, that cycle type never hits.
- R4: With control bit 7 = 1 (memory), control bits 6:0 mask A[15:9] (bit 0 for A9), A[8:0] are never compared, and both read and write cycles can hit.
- R5: An I/O-mode window hits only cycles with bus_mem = 0. A memory-mode window hits only cycles with bus_mem = 1.
- R6: trap_req is high for exactly the one clock after a bus_strobe cycle that hits any window. Without a strobe or a soft-trap write in the previous cycle, it is low.
- R7: A write to index 3 raises trap_req in the following cycle for any data value. Reading index 3 returns 00h.
- R8: Status (index 4, bit i = window i) sets the bit of every window hit by a strobed access. Writing 1s clears bits. A hit wins over a clear of the same bit in the same cycle. match_flags mirrors status.
- R9: Reserved indices (5, 6, 7, 14, 15) read 00h, and writes to them change no register.
- R10: Address activity without bus_strobe changes neither trap_req nor status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_idx | input | 4 | Register index |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_idx (combinational) |
| bus_strobe | input | 1 | Marks a valid bus access this cycle |
| bus_write | input | 1 | 1 = write cycle, 0 = read cycle |
| bus_mem | input | 1 | 1 = memory space, 0 = I/O space |
| bus_addr | input | 16 | Access address |
| match_flags | output | 3 | Sticky per-window match status |
| trap_req | output | 1 | Single-cycle trap request |

## Verification
The assertions assume that bus_write, bus_mem and bus_addr are stable and meaningful whenever bus_strobe is high. They also assume that register accesses are single-cycle and happen only when reset has been released. The bench changes every input only on the falling clock edge. It holds each strobe for exactly one cycle and returns bus_strobe and reg_we to 0 between operations. The one exception is the deliberate cycle in which a strobe and a status clear coincide.

// File: rtl/atd_pkg.sv
package atd_pkg;
  localparam int ADDR_W    = 16;
  localparam int DATA_W    = 8;
  localparam int IO_MASK_W = 5;
  localparam int MEM_MASK_W = 7;
  localparam int MEM_LSB   = ADDR_W - MEM_MASK_W;

  typedef struct packed {
    logic                  mem_sel;
    logic                  wr_track;
    logic                  rd_track;
    logic [IO_MASK_W-1:0]  io_mask;
  } win_ctrl_t;
endpackage

// File: rtl/atd_regfile.sv
module atd_regfile
  import atd_pkg::*;
#(
  parameter int NWIN  = 3,
  parameter int IDX_W = 4
) (
  input  logic                          clk,
  input  logic                          rst_ni,
  input  logic [IDX_W-1:0]              reg_idx,
  input  logic                          reg_we,
  input  logic [DATA_W-1:0]             reg_wdata,
  input  logic [NWIN-1:0]               status_i,
  output logic [DATA_W-1:0]             reg_rdata,
  output logic [NWIN-1:0][DATA_W-1:0]   ctrl_o,
  output logic [NWIN-1:0][ADDR_W-1:0]   base_o,
  output logic                          soft_we_o,
  output logic [NWIN-1:0]               status_clr_o
);
  localparam logic [IDX_W-1:0] SOFT_IDX  = IDX_W'(NWIN);
  localparam logic [IDX_W-1:0] STAT_IDX  = IDX_W'(NWIN + 1);
  localparam int               BASE_IDX0 = 2 ** (IDX_W - 1);

  logic [NWIN-1:0][DATA_W-1:0] ctrl_q, ctrl_d;
  logic [NWIN-1:0][ADDR_W-1:0] base_q, base_d;
  logic [NWIN-1:0]             ctrl_en;
  logic [NWIN-1:0]             base_lo_en, base_hi_en;

  // write decode per window
  for (genvar w = 0; w < NWIN; w++) begin : g_dec
    assign ctrl_en[w]    = reg_we && (reg_idx == IDX_W'(w));
    assign base_lo_en[w] = reg_we && (reg_idx == IDX_W'(BASE_IDX0 + 2*w));
    assign base_hi_en[w] = reg_we && (reg_idx == IDX_W'(BASE_IDX0 + 2*w + 1));
  end

  always_comb begin
    ctrl_d = ctrl_q;
    base_d = base_q;
    for (int w = 0; w < NWIN; w++) begin
      if (ctrl_en[w])    ctrl_d[w] = reg_wdata;
      if (base_lo_en[w]) base_d[w][DATA_W-1:0] = reg_wdata;
      if (base_hi_en[w]) base_d[w][ADDR_W-1:DATA_W] = reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      base_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      base_q <= base_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_idx == STAT_IDX) reg_rdata = DATA_W'(status_i);
    for (int w = 0; w < NWIN; w++) begin
      if (reg_idx == IDX_W'(w))                  reg_rdata = ctrl_q[w];
      if (reg_idx == IDX_W'(BASE_IDX0 + 2*w))     reg_rdata = base_q[w][DATA_W-1:0];
      if (reg_idx == IDX_W'(BASE_IDX0 + 2*w + 1)) reg_rdata = base_q[w][ADDR_W-1:DATA_W];
    end
  end

  assign soft_we_o    = reg_we && (reg_idx == SOFT_IDX);
  assign status_clr_o = (reg_we && (reg_idx == STAT_IDX)) ? reg_wdata[NWIN-1:0] : '0;
  assign ctrl_o       = ctrl_q;
  assign base_o       = base_q;

  logic known_idx;
  always_comb begin
    known_idx = (reg_idx == SOFT_IDX) || (reg_idx == STAT_IDX);
    for (int w = 0; w < NWIN; w++)
      if (reg_idx == IDX_W'(w) || reg_idx == IDX_W'(BASE_IDX0 + 2*w) ||
          reg_idx == IDX_W'(BASE_IDX0 + 2*w + 1))
        known_idx = 1'b1;
  end

  // R9: a write to a reserved index leaves every window register untouched
  p_reserved_write_ignored_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    (reg_we && !known_idx) |=> ($stable(ctrl_q) && $stable(base_q)));

  // R7: the soft-trap index always reads zero
  always_comb begin
    if (rst_ni && reg_idx == SOFT_IDX)
      p_soft_reads_zero_r7: assert (reg_rdata == '0);
  end
endmodule

// File: rtl/atd_win_cmp.sv
module atd_win_cmp
  import atd_pkg::*;
(
  input  logic [DATA_W-1:0] ctrl_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              bus_strobe,
  input  logic              bus_write,
  input  logic              bus_mem,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              hit_o
);
  win_ctrl_t             ctl;
  logic [ADDR_W-1:0]     diff;
  logic [ADDR_W-1:0]     io_care;
  logic [MEM_MASK_W-1:0] mem_care;
  logic                  io_hit, mem_hit, cyc_ok;

  assign ctl      = win_ctrl_t'(ctrl_i);
  assign diff     = bus_addr ^ base_i;
  assign io_care  = ~{{(ADDR_W-IO_MASK_W){1'b0}}, ctl.io_mask};
  assign mem_care = ~ctrl_i[MEM_MASK_W-1:0];

  assign cyc_ok  = bus_write ? ctl.wr_track : ctl.rd_track;
  assign io_hit  = !ctl.mem_sel && !bus_mem && cyc_ok && ((diff & io_care) == '0);
  assign mem_hit = ctl.mem_sel && bus_mem &&
                   ((diff[ADDR_W-1:MEM_LSB] & mem_care) == '0);
  assign hit_o   = bus_strobe && (io_hit || mem_hit);
endmodule

// File: rtl/atd_trap_ctrl.sv
module atd_trap_ctrl #(
  parameter int NWIN = 3
) (
  input  logic            clk,
  input  logic            rst_ni,
  input  logic [NWIN-1:0] hit_i,
  input  logic            soft_we_i,
  input  logic [NWIN-1:0] status_clr_i,
  output logic [NWIN-1:0] status_o,
  output logic            trap_o
);
  logic [NWIN-1:0] status_q, status_d;
  logic            trap_q, trap_d;

  always_comb begin
    status_d = (status_q & ~status_clr_i) | hit_i;
    trap_d   = (|hit_i) || soft_we_i;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      trap_q   <= 1'b0;
    end else begin
      status_q <= status_d;
      trap_q   <= trap_d;
    end
  end

  assign status_o = status_q;
  assign trap_o   = trap_q;

  // R8: every window hit is recorded in status on the next cycle
  p_hit_sets_status_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    (|hit_i) |=> ((status_q & $past(hit_i)) == $past(hit_i)));

  // R8: a clear without a coincident hit leaves the bit at zero
  p_clear_wins_without_hit_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    (|(status_clr_i & ~hit_i)) |=> ((status_q & $past(status_clr_i & ~hit_i)) == '0));
endmodule

// File: rtl/addr_trap_decoder.sv
module addr_trap_decoder
  import atd_pkg::*;
#(
  parameter int NWIN  = 3,
  parameter int IDX_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [IDX_W-1:0]    reg_idx,
  input  logic                reg_we,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic                bus_strobe,
  input  logic                bus_write,
  input  logic                bus_mem,
  input  logic [ADDR_W-1:0]   bus_addr,
  output logic [NWIN-1:0]     match_flags,
  output logic                trap_req
);
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  logic [NWIN-1:0][DATA_W-1:0] ctrl;
  logic [NWIN-1:0][ADDR_W-1:0] base;
  logic [NWIN-1:0]             hit;
  logic [NWIN-1:0]             status_clr;
  logic                        soft_we;

  atd_regfile #(.NWIN(NWIN), .IDX_W(IDX_W)) u_regs (
    .clk          (clk),
    .rst_ni       (rst_ni),
    .reg_idx      (reg_idx),
    .reg_we       (reg_we),
    .reg_wdata    (reg_wdata),
    .status_i     (match_flags),
    .reg_rdata    (reg_rdata),
    .ctrl_o       (ctrl),
    .base_o       (base),
    .soft_we_o    (soft_we),
    .status_clr_o (status_clr)
  );

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    atd_win_cmp u_cmp (
      .ctrl_i     (ctrl[w]),
      .base_i     (base[w]),
      .bus_strobe (bus_strobe),
      .bus_write  (bus_write),
      .bus_mem    (bus_mem),
      .bus_addr   (bus_addr),
      .hit_o      (hit[w])
    );

    // R3: an I/O window with a disabled cycle type never hits that type
    p_io_track_gate_r3: assert property (@(posedge clk) disable iff (!rst_ni)
      (!ctrl[w][7] && bus_strobe && !bus_mem &&
       ((bus_write && !ctrl[w][6]) || (!bus_write && !ctrl[w][5]))) |-> !hit[w]);

    // R5: space select keeps windows away from the other space
    p_space_select_r5: assert property (@(posedge clk) disable iff (!rst_ni)
      (bus_mem != ctrl[w][7]) |-> !hit[w]);
  end

  atd_trap_ctrl #(.NWIN(NWIN)) u_trap (
    .clk          (clk),
    .rst_ni       (rst_ni),
    .hit_i        (hit),
    .soft_we_i    (soft_we),
    .status_clr_i (status_clr),
    .status_o     (match_flags),
    .trap_o       (trap_req)
  );

  // R6: no trap without a strobe or soft-trap write one cycle earlier
  p_trap_needs_cause_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (!bus_strobe && !(reg_we && reg_idx == IDX_W'(NWIN))) |=> !trap_req);

  // R10: no strobe and no status write keeps the status byte unchanged
  p_status_quiet_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    (!bus_strobe && !(reg_we && reg_idx == IDX_W'(NWIN + 1))) |=> $stable(match_flags));
endmodule

// File: tb/addr_trap_decoder_bench.sv
module addr_trap_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  reg_idx;
  logic        reg_we;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic        bus_strobe, bus_write, bus_mem;
  logic [15:0] bus_addr;
  logic [2:0]  match_flags;
  logic        trap_req;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  addr_trap_decoder u_addr_trap_decoder (
    .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_strobe(bus_strobe),
    .bus_write(bus_write), .bus_mem(bus_mem), .bus_addr(bus_addr),
    .match_flags(match_flags), .trap_req(trap_req)
  );

  typedef struct packed {
    logic [7:0]  ctrl;
    logic [15:0] base;
    logic        mem;
    logic        wr;
    logic [15:0] addr;
    logic        hit;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{8'h60, 16'h0300, 1'b0, 1'b1, 16'h0300, 1'b1}, // R2 exact
    '{8'h60, 16'h0300, 1'b0, 1'b1, 16'h0301, 1'b0}, // R2 A0 compared
    '{8'h7F, 16'h0300, 1'b0, 1'b1, 16'h031F, 1'b1}, // R2 A4:0 masked
    '{8'h7F, 16'h0300, 1'b0, 1'b0, 16'h0320, 1'b0}, // R2 A5 always compared
    '{8'h20, 16'h0300, 1'b0, 1'b1, 16'h0300, 1'b0}, // R3 write untracked
    '{8'h20, 16'h0300, 1'b0, 1'b0, 16'h0300, 1'b1}, // R3 read tracked
    '{8'h40, 16'h0300, 1'b0, 1'b0, 16'h0300, 1'b0}, // R3 read untracked
    '{8'h80, 16'hA000, 1'b1, 1'b0, 16'hA1FF, 1'b1}, // R4 A8:0 ignored
    '{8'h80, 16'hA000, 1'b1, 1'b1, 16'hA200, 1'b0}, // R4 A9 compared
    '{8'h83, 16'hA000, 1'b1, 1'b1, 16'hA600, 1'b1}, // R4 A10:9 masked, write
    '{8'hFF, 16'hA000, 1'b1, 1'b0, 16'h1234, 1'b1}, // R4 64 KB window
    '{8'h80, 16'hA000, 1'b0, 1'b0, 16'hA000, 1'b0}, // R5 I/O cycle on mem window
    '{8'h60, 16'h0300, 1'b1, 1'b1, 16'h0300, 1'b0}  // R5 mem cycle on I/O window
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [3:0] idx, logic [7:0] d);
    @(negedge clk);
    reg_idx = idx; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_reg(logic [3:0] idx, output logic [7:0] d);
    @(negedge clk);
    reg_idx = idx; reg_we = 1'b0;
    #1 d = reg_rdata;
  endtask

  task automatic access(logic mem, logic wr, logic [15:0] a);
    @(negedge clk);
    bus_mem = mem; bus_write = wr; bus_addr = a; bus_strobe = 1'b1;
    @(negedge clk);
    bus_strobe = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [7:0] d;
    rst_n = 1'b0; reg_idx = '0; reg_we = 1'b0; reg_wdata = '0;
    bus_strobe = 1'b0; bus_write = 1'b0; bus_mem = 1'b0; bus_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    for (int i = 0; i < 3; i++) begin
      rd_reg(4'(i), d);       chk("R1 ctrl reset", d, 8'h00);
      rd_reg(4'(8 + 2*i), d); chk("R1 base lo reset", d, 8'h00);
      rd_reg(4'(9 + 2*i), d); chk("R1 base hi reset", d, 8'h00);
    end
    chk("R6 trap reset", trap_req, 0);
    chk("R8 status reset", match_flags, 0);

    // vector table on window 0
    for (int v = 0; v < NV; v++) begin
      wr_reg(4'd0, VECS[v].ctrl);
      wr_reg(4'd8, VECS[v].base[7:0]);
      wr_reg(4'd9, VECS[v].base[15:8]);
      wr_reg(4'd4, 8'h07);
      access(VECS[v].mem, VECS[v].wr, VECS[v].addr);
      chk($sformatf("R2-5 vec%0d trap", v), trap_req, VECS[v].hit);
      chk($sformatf("R8 vec%0d status", v), match_flags, {2'b00, VECS[v].hit});
      @(negedge clk);
      chk($sformatf("R6 vec%0d pulse ends", v), trap_req, 0);
    end

    // R1 readback
    wr_reg(4'd1, 8'h5A); rd_reg(4'd1, d); chk("R1 ctrl readback", d, 8'h5A);
    wr_reg(4'd13, 8'hC3); rd_reg(4'd13, d); chk("R1 base hi readback", d, 8'hC3);

    // R7 soft trap with two data values
    wr_reg(4'd3, 8'h00); chk("R7 soft trap 00", trap_req, 1);
    @(negedge clk); chk("R7 pulse ends", trap_req, 0);
    wr_reg(4'd3, 8'hFF); chk("R7 soft trap FF", trap_req, 1);
    rd_reg(4'd3, d); chk("R7 soft reads zero", d, 8'h00);

    // R9 reserved index
    wr_reg(4'd2, 8'h11);
    wr_reg(4'd5, 8'hEE); rd_reg(4'd5, d); chk("R9 reserved reads zero", d, 8'h00);
    wr_reg(4'd14, 8'hEE); rd_reg(4'd14, d); chk("R9 reserved 14 zero", d, 8'h00);
    rd_reg(4'd2, d); chk("R9 ctrl untouched", d, 8'h11);

    // R8 multi-window and set-over-clear
    wr_reg(4'd0, 8'h00);
    wr_reg(4'd1, 8'h80); wr_reg(4'd10, 8'h00); wr_reg(4'd11, 8'h40);
    wr_reg(4'd2, 8'h81); wr_reg(4'd12, 8'h00); wr_reg(4'd13, 8'h42);
    wr_reg(4'd4, 8'h07);
    access(1'b1, 1'b0, 16'h4000);
    chk("R8 two windows", match_flags, 3'b110);
    rd_reg(4'd4, d); chk("R8 status read", d, 8'h06);
    @(negedge clk);
    reg_idx = 4'd4; reg_wdata = 8'h02; reg_we = 1'b1;
    bus_mem = 1'b1; bus_write = 1'b0; bus_addr = 16'h4000; bus_strobe = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; bus_strobe = 1'b0;
    chk("R8 set wins over clear", match_flags, 3'b110);
    wr_reg(4'd4, 8'h04); chk("R8 W1C one bit", match_flags, 3'b010);

    // R10 no strobe
    @(negedge clk);
    bus_mem = 1'b1; bus_addr = 16'h4000; bus_strobe = 1'b0;
    @(negedge clk);
    chk("R10 no trap without strobe", trap_req, 0);
    chk("R10 status unchanged", match_flags, 3'b010);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule